// File: doc/BRIEF.md
# Keyed-Touch Watchdog Timer

This block is a watchdog with a small byte-wide register interface. A slow reference tick, presented as a one-cycle enable on the system clock, passes through two power-of-two dividers and then clocks an 8-bit down-counter. Software keeps the system alive by writing a fixed key byte, 0x5C, to a touch register. A valid touch restarts the count from a programmed reload value. If the count runs down to zero, the block raises a one-cycle reset request and sets a sticky status flag. The reset network clears that flag by writing one to it.

After reset the block is idle. It starts counting only once software issues a reload command. Touches can be rate-limited. With the early-touch guard active, a keyed touch that arrives while the count is still above a programmable threshold is treated as a fault. It raises the reset request at once. The live count can be read at any time.

Register map (3-bit address): 0 control (bit 0 reload command, bit 1 early-touch guard disable, bit 2 reset status), 1 first-stage divider select, 2 second-stage divider select, 3 configuration (bit 0 key-touch enable, bit 1 tick source), 4 reload value on write and live count on read, 5 touch key (write only, reads 0), 6 early-touch threshold.

Top module: `kwdt_top`

## Requirements
- R1: After reset, control reads 0x00, the live count reads 0 and rst_req is low. The counter does not move and no reset request is raised until the first reload command, whatever ref_tick does.
- R2: Writing 1 to control bit 0 makes that bit read 1 in the following cycle. One cycle later the bit reads 0, and the live count equals the reload value. The write also clears both dividers.
- R3: With configuration bit 1 set, the count drops by one every 2^T·2^W ref_tick pulses, where T is the first-stage select and W is the second-stage select. With bit 1 clear, the first stage is bypassed and the count drops every 2^W pulses.
- R4: When the count reaches 0, rst_req is high for exactly one cycle and control bit 2 is set. The count then stays at 0 and raises no further request until it is reloaded.
- R5: Writing 1 to control bit 2 clears the status. Writing 0 to it leaves the status unchanged.
- R6: When key touch is enabled (configuration bit 0 set) and the block is running, writing 0x5C to address 5 reloads the count on the same edge and restarts both dividers.
- R7: Writing any byte other than 0x5C to address 5 has no effect. Writing 0x5C has no effect while configuration bit 0 is clear.
- R8: With control bit 1 clear, a keyed touch taken while the count is above the threshold (address 6, reset value 0xFF) leaves the count unchanged, raises a one-cycle rst_req and sets the status. A keyed touch taken at or below the threshold reloads normally.
- R9: With control bit 1 set, a keyed touch reloads the count at any count value.
- R10: Reading address 4 returns the live count after each decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per slow reference clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench first sweeps the divider selects and the tick source against reload values. A divider that drops a tick, or one that ignores the bypass, shows up as a wrong count. A counter that wraps below zero or keeps firing from zero shows up on the run-down vector.

Directed cases then cover the following:
- the reload bit, which must read back set for exactly one cycle;
- a status bit that must clear only on a written one;
- a touch that lands after a partial divider period, where a divider that is not restarted would decrement too early;
- a near-miss key byte and a touch with the key disabled, both of which must leave the count untouched;
- a touch just above and just below the threshold, where getting the comparison wrong either lets an early touch through or resets a legal one.

// File: rtl/kwdt_pkg.sv
// Shared constants for the keyed-touch watchdog: register addresses,
// bit positions and the touch key. Assumes a 3-bit byte-wide register bus.
package kwdt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TSEL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_WSEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_TOUCH = 3'd5;
    localparam logic [ADDR_W-1:0] A_THR   = 3'd6;

    localparam int B_RLD    = 0;
    localparam int B_ETD    = 1;
    localparam int B_STS    = 2;
    localparam int B_KEY_EN = 0;
    localparam int B_SRC    = 1;

    localparam logic [DATA_W-1:0] TOUCH_KEY = 8'h5C;
endpackage

// File: rtl/kwdt_prediv.sv
// One power-of-two divider stage. Emits tick_out on every 2^sel-th tick_in.
// Assumes tick_in is a one-cycle enable. clr restarts the stage.
module kwdt_prediv #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int ACC_W = (1 << SEL_W) - 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] mask;

    // Low sel bits of the accumulator that must all be one to emit a tick
    always_comb begin
        mask = ~({ACC_W{1'b1}} << sel);
    end

    assign tick_out = tick_in && !clr && ((acc & mask) == mask);

    // Count input ticks, restarting on clear
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (clr)     acc <= '0;
        else if (tick_in) acc <= acc + 1'b1;
    end
endmodule

// File: rtl/kwdt_downcnt.sv
// Watchdog down-counter. Loads on load and steps down on tick while armed.
// Holds at zero. expire flags the step from 1 to 0.
module kwdt_downcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = armed && !load && tick && (count == ONE);

    // Load has priority, otherwise decrement towards zero on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)                             count <= '0;
        else if (load)                          count <= ld_val;
        else if (armed && tick && count != '0)  count <= count - ONE;
    end
endmodule

// File: rtl/kwdt_regs.sv
// Register file and touch decoding. Holds the selects, configuration,
// reload value, threshold and status. Decides when the counter is loaded
// and when a touch is early. Assumes a single-cycle write strobe.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              set_status,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  tsel,
    output logic [SEL_W-1:0]  wsel,
    output logic              src_sel,
    output logic [CNT_W-1:0]  reload_val,
    output logic              reload_pend,
    output logic              load,
    output logic              armed,
    output logic              early_viol,
    output logic              status
);
    logic             etd;
    logic             key_en;
    logic [CNT_W-1:0] thr;
    logic             wr_ctrl;
    logic             key_hit;
    logic             touch_load;

    assign wr_ctrl    = wr && (addr == A_CTRL);
    assign key_hit    = wr && (addr == A_TOUCH) && (wdata == TOUCH_KEY) && key_en && armed;
    assign early_viol = key_hit && !etd && (count > thr);
    assign touch_load = key_hit && !early_viol;
    assign load       = reload_pend || touch_load;

    // Control bits: one-cycle reload command, guard disable, armed latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_pend <= 1'b0;
            etd         <= 1'b0;
            armed       <= 1'b0;
        end else begin
            reload_pend <= wr_ctrl && wdata[B_RLD];
            if (wr_ctrl) etd <= wdata[B_ETD];
            if (reload_pend) armed <= 1'b1;
        end
    end

    // Sticky status: a new event wins over a write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                        status <= 1'b0;
        else if (set_status)               status <= 1'b1;
        else if (wr_ctrl && wdata[B_STS])  status <= 1'b0;
    end

    // Plain read/write fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsel       <= '0;
            wsel       <= '0;
            key_en     <= 1'b0;
            src_sel    <= 1'b0;
            reload_val <= '1;
            thr        <= '1;
        end else if (wr) begin
            case (addr)
                A_TSEL:  tsel <= wdata[SEL_W-1:0];
                A_WSEL:  wsel <= wdata[SEL_W-1:0];
                A_CFG: begin
                    key_en  <= wdata[B_KEY_EN];
                    src_sel <= wdata[B_SRC];
                end
                A_COUNT: reload_val <= wdata[CNT_W-1:0];
                A_THR:   thr <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_RLD] = reload_pend;
                rdata[B_ETD] = etd;
                rdata[B_STS] = status;
            end
            A_TSEL:  rdata[SEL_W-1:0] = tsel;
            A_WSEL:  rdata[SEL_W-1:0] = wsel;
            A_CFG: begin
                rdata[B_KEY_EN] = key_en;
                rdata[B_SRC]    = src_sel;
            end
            A_COUNT: rdata[CNT_W-1:0] = count;
            A_THR:   rdata[CNT_W-1:0] = thr;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_top.sv
// Keyed-touch watchdog top. It chains the two divider stages, the counter and the
// register file, and registers the reset request. Assumes ref_tick is a
// one-cycle enable on clk and that CNT_W equals the 8-bit bus width.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic [SEL_W-1:0] tsel, wsel;
    logic             src_sel;
    logic [CNT_W-1:0] reload_val, live_count;
    logic             reload_pend, do_load, armed, early_viol, status_bit;
    logic             t1_tick, src_tick, cnt_tick, expire, fire;

    assign fire     = expire || early_viol;
    assign src_tick = src_sel ? t1_tick : ref_tick;

    kwdt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .count(live_count), .set_status(fire),
        .rdata(bus_rdata), .tsel(tsel), .wsel(wsel), .src_sel(src_sel),
        .reload_val(reload_val), .reload_pend(reload_pend), .load(do_load),
        .armed(armed), .early_viol(early_viol), .status(status_bit)
    );

    kwdt_prediv #(.SEL_W(SEL_W)) u_div_t (
        .clk(clk), .rst_n(rst_n), .clr(do_load), .tick_in(ref_tick),
        .sel(tsel), .tick_out(t1_tick)
    );

    kwdt_prediv #(.SEL_W(SEL_W)) u_div_w (
        .clk(clk), .rst_n(rst_n), .clr(do_load), .tick_in(src_tick),
        .sel(wsel), .tick_out(cnt_tick)
    );

    kwdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .armed(armed), .load(do_load),
        .ld_val(reload_val), .tick(cnt_tick), .count(live_count),
        .expire(expire)
    );

    // Register the reset request so it is a clean one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= fire;
    end
endmodule

// File: rtl/kwdt_checker.sv
// Property checker for kwdt_top, attached by bind. Observes ports and the
// nets between the register file and the counter.
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rst_req,
    input logic [CNT_W-1:0]  count,
    input logic              load,
    input logic              pend,
    input logic              armed,
    input logic              status,
    input logic [CNT_W-1:0]  reload_val
);
    logic past_ok;

    // Marks that at least one cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_idle_until_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (count == '0 && !rst_req));

    assert_reload_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[B_RLD]) |=> pend);

    assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (count == $past(reload_val)));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(load)) |->
            (count == $past(count) || count == $past(count) - CNT_W'(1)));

    assert_req_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> status);

    assert_bad_key_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TOUCH && bus_wdata != TOUCH_KEY) |-> (!load || pend));
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) u_kwdt_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rst_req(rst_req), .count(live_count),
    .load(do_load), .pend(reload_pend), .armed(armed),
    .status(status_bit), .reload_val(reload_val)
);

// File: tb/test_kwdt_top.sv
// Self-checking bench for kwdt_top: a vector table of divider settings,
// then directed tests from a fresh reset.
module test_kwdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int rst_seen = 0;
    int wide = 0;
    logic prev_req = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kwdt_top i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    // Count reset request pulses and any pulse longer than one cycle
    always @(negedge clk) begin
        if (rst_req) rst_seen++;
        if (rst_req && prev_req) wide++;
        prev_req = rst_req;
    end

    // tsel, wsel, src, reload, ref pulses
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{0, 0, 0, 10, 3},
        '{1, 0, 1, 10, 6},
        '{0, 2, 0, 20, 9},
        '{2, 1, 1, 20, 17},
        '{3, 0, 0, 5, 4},
        '{1, 1, 1, 3, 40}
    };

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int v, base, dv, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table: divider and source settings, live count read-back (R3, R10)
        for (int k = 0; k < NV; k++) begin
            wr(3'd1, 8'(VEC[k][0]));
            wr(3'd2, 8'(VEC[k][1]));
            wr(3'd3, 8'(VEC[k][2] * 2 + 1));
            wr(3'd4, 8'(VEC[k][3]));
            wr(3'd0, 8'h03);
            @(negedge clk);
            pulses(VEC[k][4]);
            dv = (1 << VEC[k][1]) * ((VEC[k][2] != 0) ? (1 << VEC[k][0]) : 1);
            ex = (VEC[k][4] / dv >= VEC[k][3]) ? 0 : VEC[k][3] - VEC[k][4] / dv;
            rd(3'd4, v);
            check("R3/R10 divided count", v, ex);
        end

        // R1: reset state and idle before the first reload
        do_reset();
        base = rst_seen;
        rd(3'd0, v); check("R1 ctrl after reset", v, 0);
        rd(3'd4, v); check("R1 count after reset", v, 0);
        check("R1 rst_req low", int'(rst_req), 0);
        pulses(10);
        rd(3'd4, v); check("R1 idle count", v, 0);
        check("R1 no request while idle", rst_seen - base, 0);

        // R2: reload bit reads back for one cycle, then count is loaded
        wr(3'd4, 8'd3);
        wr(3'd0, 8'h03);
        rd(3'd0, v); check("R2 reload bit set", v, 3);
        @(negedge clk);
        rd(3'd0, v); check("R2 reload bit cleared", v, 2);
        rd(3'd4, v); check("R2 loaded count", v, 3);

        // R4: expiry pulse, status, hold at zero
        base = rst_seen;
        pulses(3);
        @(negedge clk);
        check("R4 one request", rst_seen - base, 1);
        rd(3'd0, v); check("R4 status set", v, 6);
        rd(3'd4, v); check("R4 count zero", v, 0);
        pulses(5);
        rd(3'd4, v); check("R4 holds at zero", v, 0);
        check("R4 no repeat request", rst_seen - base, 1);

        // R5: status write-one-to-clear
        wr(3'd0, 8'h02);
        rd(3'd0, v); check("R5 write zero keeps status", v, 6);
        wr(3'd0, 8'h06);
        rd(3'd0, v); check("R5 write one clears", v, 2);

        // R6: keyed touch reloads and restarts the dividers
        wr(3'd3, 8'h01);
        wr(3'd4, 8'd10);
        wr(3'd0, 8'h03);
        @(negedge clk);
        pulses(4);
        rd(3'd4, v); check("R6 before touch", v, 6);
        wr(3'd5, 8'h5C);
        rd(3'd4, v); check("R6 touch reload", v, 10);
        wr(3'd2, 8'd2);
        pulses(3);
        wr(3'd5, 8'h5C);
        pulses(3);
        rd(3'd4, v); check("R6 divider restarted", v, 10);
        pulses(1);
        rd(3'd4, v); check("R6 first step after touch", v, 9);
        wr(3'd2, 8'd0);

        // R7: wrong key and disabled key are ignored
        base = rst_seen;
        wr(3'd5, 8'h5D);
        rd(3'd4, v); check("R7 wrong key ignored", v, 9);
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h5C);
        rd(3'd4, v); check("R7 key disabled ignored", v, 9);
        check("R7 no request", rst_seen - base, 0);
        wr(3'd3, 8'h01);

        // R8: early touch above threshold fires, at threshold reloads
        wr(3'd6, 8'd5);
        wr(3'd0, 8'h00);
        base = rst_seen;
        wr(3'd5, 8'h5C);
        @(negedge clk);
        check("R8 early touch request", rst_seen - base, 1);
        rd(3'd4, v); check("R8 count unchanged", v, 9);
        rd(3'd0, v); check("R8 status set", v, 4);
        wr(3'd0, 8'h04);
        pulses(4);
        base = rst_seen;
        wr(3'd5, 8'h5C);
        rd(3'd4, v); check("R8 touch at threshold reloads", v, 10);
        @(negedge clk);
        check("R8 no request at threshold", rst_seen - base, 0);

        // R9: guard disabled accepts a touch above threshold
        wr(3'd0, 8'h02);
        pulses(1);
        base = rst_seen;
        wr(3'd5, 8'h5C);
        rd(3'd4, v); check("R9 touch above threshold", v, 10);
        @(negedge clk);
        check("R9 no request", rst_seen - base, 0);

        check("R4 pulse width one cycle", wide, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule